// File: doc/BRIEF.md
# Command-Driven PASID Allocator Register Block

This block gives software a small register window through which it asks for a process address-space identifier (PASID) to be allocated or released. Software writes a command word. The block then works the command against a local pool of identifiers and posts the outcome in a response register. The response holds a busy flag, a two-bit status code and, for a successful allocation, the granted identifier. Software polls the response until the busy flag drops.

The window holds three 64-bit registers: a read-only capability word, the command word and a read-only response word. Each one can be reached with a 64-bit access at its base offset, or with 32-bit accesses to its lower half (base) and upper half (base + 4). The pool is a bitmap sized by a parameter. An allocation grants the lowest free identifier and scans one bitmap word per cycle. Identifier 0 is reserved and is never granted.

Top module: `pasid_vcmd_regs`

## Requirements
- R1: The capability register at offset 0xE00 reads bit 0 = `ALLOC_SUPPORT` and all other bits 0. Writes to it change nothing.
- R2: The command register is at 0xE10 and the response register at 0xE20. A 64-bit access uses the base offset. A 32-bit access at base reaches bits 31:0, and a 32-bit access at base+4 reaches bits 63:32. Any write to either half of the command register issues the command held in the updated word.
- R3: When `ALLOC_SUPPORT` is 0, command writes are rejected: the command register stays 0 and the response stays 0.
- R4: An accepted command write makes the response read exactly 0x1 on the next cycle: busy flag set, with status code and result cleared.
- R5: A command write that arrives while the busy flag (response bit 0) is set is ignored. The command register keeps its old value and the running command completes normally.
- R6: Opcode 1 (command bits 7:0) allocates the lowest free identifier. It ends with status 0 and the identifier in response bits 27:8, so the response is id<<8. Busy lasts 1 + id/WORD_W cycles, and 0 is never granted.
- R7: An allocate with the pool full ends with status code 2 (response 0x4) after NUM_PASID/WORD_W busy cycles.
- R8: Opcode 2 frees the identifier in command bits 27:8. A valid free ends with response 0x0 after one busy cycle, and the identifier can be allocated again.
- R9: Freeing identifier 0, an identifier of NUM_PASID or above, or an identifier not currently allocated ends with response 0x4 (status code 2 in bits 2:1) after one busy cycle and leaves the pool unchanged.
- R10: Any other opcode, including the null opcode 0, ends with status code 1 (response 0x2) after one busy cycle.
- R11: Reset clears the command register, the response register and the whole pool, so the first allocate afterwards returns identifier 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Write strobe qualifier for this cycle |
| bus_write | input | 1 | 1 = write access |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 64 | Write data (bits 31:0 used by 32-bit writes) |
| bus_rdata | output | 64 | Combinational read data for `bus_addr` |

## Verification
The pool is first filled one allocate at a time. Each result and each busy length is compared with the lowest-free identifier and the word index that a bench model computes, which shows whether the search order and the per-word pacing are right. Every even identifier is then freed and the pool refilled. This shows whether freed holes are reused lowest first, ahead of untouched space. Invalid frees of 0, of an out-of-pool identifier and of an identifier already released are checked to change nothing. Undefined and null opcodes, a write during a long search, half-word command writes and a block built without allocation support each separate one way the command is accepted or rejected.

// File: rtl/pasid_vcmd_pkg.sv
package pasid_vcmd_pkg;
    localparam int PASID_W = 20;

    localparam logic [11:0] CAP_OFS  = 12'hE00;
    localparam logic [11:0] CMD_OFS  = 12'hE10;
    localparam logic [11:0] RESP_OFS = 12'hE20;

    localparam logic [7:0] OP_ALLOC = 8'd1;
    localparam logic [7:0] OP_FREE  = 8'd2;

    localparam logic [63:0] RESP_BUSY  = 64'h1;
    localparam logic [63:0] RESP_UNDEF = 64'h2;  // status 1 in bits 2:1
    localparam logic [63:0] RESP_NOID  = 64'h4;  // status 2 in bits 2:1

    typedef enum logic [1:0] {
        P_IDLE,
        P_SCAN,
        P_FREE
    } pool_state_e;
endpackage

// File: rtl/pasid_word_scan.sv
module pasid_word_scan #(
    parameter int WORD_W = 16,
    localparam int BIT_W = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] word,
    output logic              found,
    output logic [BIT_W-1:0]  pos
);
    // lowest clear bit wins: walk downward so the last hit is the lowest
    always_comb begin
        found = 1'b0;
        pos   = '0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (!word[i]) begin
                found = 1'b1;
                pos   = BIT_W'(i);
            end
        end
    end
endmodule

// File: rtl/pasid_pool.sv
module pasid_pool
    import pasid_vcmd_pkg::*;
#(
    parameter int NUM_PASID = 64,
    parameter int WORD_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_start,
    input  logic               free_start,
    input  logic [PASID_W-1:0] free_id,
    output logic               done,
    output logic               fail,
    output logic [PASID_W-1:0] result
);
    localparam int NUM_WORDS = NUM_PASID / WORD_W;
    localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int BIT_W     = $clog2(WORD_W);
    localparam int ID_W      = $clog2(NUM_PASID);

    typedef struct packed {
        pool_state_e          state;
        logic [WIDX_W-1:0]    widx;
        logic [NUM_PASID-1:0] used;
        logic [PASID_W-1:0]   fid;
    } pool_t;

    pool_t st_d, st_q;

    logic [WORD_W-1:0] words [NUM_WORDS];
    logic              hit;
    logic [BIT_W-1:0]  hit_pos;
    logic [ID_W-1:0]   hit_id;
    logic              fid_ok;

    // identifier 0 is presented as permanently taken
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign words[w] = st_q.used[w*WORD_W +: WORD_W]
                        | {{(WORD_W-1){1'b0}}, (w == 0)};
    end

    pasid_word_scan #(.WORD_W(WORD_W)) u_scan (
        .word  (words[st_q.widx]),
        .found (hit),
        .pos   (hit_pos)
    );

    assign hit_id = ID_W'(st_q.widx) * ID_W'(WORD_W) + ID_W'(hit_pos);
    assign fid_ok = (st_q.fid < PASID_W'(NUM_PASID)) && (st_q.fid != '0)
                 && st_q.used[st_q.fid[ID_W-1:0]];

    always_comb begin
        st_d   = st_q;
        done   = 1'b0;
        fail   = 1'b0;
        result = '0;
        unique case (st_q.state)
            P_IDLE: begin
                if (alloc_start) begin
                    st_d.state = P_SCAN;
                    st_d.widx  = '0;
                end else if (free_start) begin
                    st_d.state = P_FREE;
                    st_d.fid   = free_id;
                end
            end
            P_SCAN: begin
                if (hit) begin
                    done              = 1'b1;
                    result            = PASID_W'(hit_id);
                    st_d.used[hit_id] = 1'b1;
                    st_d.state        = P_IDLE;
                end else if (st_q.widx == WIDX_W'(NUM_WORDS - 1)) begin
                    done       = 1'b1;
                    fail       = 1'b1;
                    st_d.state = P_IDLE;
                end else begin
                    st_d.widx = st_q.widx + WIDX_W'(1);
                end
            end
            P_FREE: begin
                done       = 1'b1;
                st_d.state = P_IDLE;
                if (fid_ok) st_d.used[st_q.fid[ID_W-1:0]] = 1'b0;
                else        fail = 1'b1;
            end
            default: st_d.state = P_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.state <= P_IDLE;
            st_q.widx  <= '0;
            st_q.used  <= '0;
            st_q.fid   <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pasid_vcmd_regs.sv
module pasid_vcmd_regs
    import pasid_vcmd_pkg::*;
#(
    parameter bit ALLOC_SUPPORT = 1'b1,
    parameter int NUM_PASID     = 64,
    parameter int WORD_W        = 16,
    parameter int ADDR_W        = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [63:0]       bus_wdata,
    output logic [63:0]       bus_rdata
);
    localparam logic [63:0] CAP_VALUE = {63'd0, ALLOC_SUPPORT};

    typedef struct packed {
        logic [63:0] cmd;
        logic [63:0] resp;
        logic        undef;
    } regs_t;

    regs_t st_d, st_q;

    logic [63:0]        cmd_q, resp_q;
    logic               hit_lo, hit_hi, accept;
    logic [63:0]        cmd_new;
    logic [7:0]         op;
    logic               alloc_start, free_start;
    logic               pool_done, pool_fail;
    logic [PASID_W-1:0] pool_result;
    logic [63:0]        rd_regs [3];
    logic [ADDR_W-1:0]  rd_ofs  [3];

    assign cmd_q  = st_q.cmd;
    assign resp_q = st_q.resp;

    assign hit_lo  = bus_valid && bus_write && (bus_addr == ADDR_W'(CMD_OFS));
    assign hit_hi  = bus_valid && bus_write && !bus_wide
                  && (bus_addr == ADDR_W'(CMD_OFS + 12'd4));
    assign cmd_new = hit_hi   ? {bus_wdata[31:0], st_q.cmd[31:0]} :
                     bus_wide ? bus_wdata :
                                {st_q.cmd[63:32], bus_wdata[31:0]};
    assign accept      = (hit_lo || hit_hi) && ALLOC_SUPPORT && !st_q.resp[0];
    assign op          = cmd_new[7:0];
    assign alloc_start = accept && (op == OP_ALLOC);
    assign free_start  = accept && (op == OP_FREE);

    pasid_pool #(.NUM_PASID(NUM_PASID), .WORD_W(WORD_W)) u_pool (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_start (alloc_start),
        .free_start  (free_start),
        .free_id     (cmd_new[8 +: PASID_W]),
        .done        (pool_done),
        .fail        (pool_fail),
        .result      (pool_result)
    );

    always_comb begin
        st_d       = st_q;
        st_d.undef = 1'b0;
        if (accept) begin
            st_d.cmd   = cmd_new;
            st_d.resp  = RESP_BUSY;
            st_d.undef = !(alloc_start || free_start);
        end
        if (st_q.undef) st_d.resp = RESP_UNDEF;
        if (pool_done) begin
            st_d.resp = pool_fail ? RESP_NOID
                                  : {{(56-PASID_W){1'b0}}, pool_result, 8'd0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cmd   <= '0;
            st_q.resp  <= '0;
            st_q.undef <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_regs[0] = CAP_VALUE;
    assign rd_regs[1] = st_q.cmd;
    assign rd_regs[2] = st_q.resp;
    assign rd_ofs[0]  = ADDR_W'(CAP_OFS);
    assign rd_ofs[1]  = ADDR_W'(CMD_OFS);
    assign rd_ofs[2]  = ADDR_W'(RESP_OFS);

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < 3; i++) begin
            if (bus_addr == rd_ofs[i]) begin
                bus_rdata = bus_wide ? rd_regs[i] : {32'd0, rd_regs[i][31:0]};
            end else if (!bus_wide && (bus_addr == rd_ofs[i] + ADDR_W'(4))) begin
                bus_rdata = {32'd0, rd_regs[i][63:32]};
            end
        end
    end
endmodule

// File: rtl/pasid_vcmd_chk.sv
module pasid_vcmd_chk #(
    parameter bit ALLOC_SUPPORT = 1'b1,
    parameter int NUM_PASID     = 64,
    parameter int ADDR_W        = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic              bus_wide,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [63:0]       bus_wdata,
    input logic [63:0]       cmd_q,
    input logic [63:0]       resp_q
);
    logic       wr_lo, wr_hi, wr_cmd, taken;
    logic [7:0] new_op;

    assign wr_lo  = bus_valid && bus_write && (bus_addr == ADDR_W'(12'hE10));
    assign wr_hi  = bus_valid && bus_write && !bus_wide
                 && (bus_addr == ADDR_W'(12'hE14));
    assign wr_cmd = wr_lo || wr_hi;
    assign taken  = wr_cmd && ALLOC_SUPPORT && !resp_q[0];
    assign new_op = wr_hi ? cmd_q[7:0] : bus_wdata[7:0];

    assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> (resp_q == 64'd1));

    assert_busy_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && resp_q[0]) |=> $stable(cmd_q));

    assert_result_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_q[27:8] != 20'd0) |-> ((resp_q[2:0] == 3'd0)
                                     && (resp_q[27:8] < 20'(NUM_PASID))));

    assert_resp_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_q[63:28] == 36'd0) && (resp_q[7:3] == 5'd0) && (resp_q[2:1] != 2'd3));

    assert_undef_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && (new_op != 8'd1) && (new_op != 8'd2)) |-> ##2 (resp_q == 64'd2));

    if (!ALLOC_SUPPORT) begin : g_nocap
        assert_no_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (resp_q == 64'd0) && (cmd_q == 64'd0));
    end
endmodule

bind pasid_vcmd_regs pasid_vcmd_chk #(
    .ALLOC_SUPPORT (ALLOC_SUPPORT),
    .NUM_PASID     (NUM_PASID),
    .ADDR_W        (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_wide  (bus_wide),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cmd_q     (cmd_q),
    .resp_q    (resp_q)
);

// File: tb/sim_pasid_vcmd_regs.sv
`timescale 1ns/1ps
module sim_pasid_vcmd_regs;
    localparam int NP = 64;
    localparam int WW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0, bus_wide = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] rdata0, rdata1;

    int tests = 0;
    int fails = 0;
    bit used [NP];

    always #10 clk = ~clk;

    pasid_vcmd_regs #(.ALLOC_SUPPORT(1'b1), .NUM_PASID(NP), .WORD_W(WW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata0));

    pasid_vcmd_regs #(.ALLOC_SUPPORT(1'b0), .NUM_PASID(NP), .WORD_W(WW)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata1));

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(logic [11:0] a, bit wide, output logic [63:0] d0,
                      output logic [63:0] d1);
        bus_addr = a;
        bus_wide = wide;
        #1;
        d0 = rdata0;
        d1 = rdata1;
    endtask

    task automatic wr(logic [11:0] a, logic [63:0] d, bit wide);
        bus_addr  = a;
        bus_wdata = d;
        bus_wide  = wide;
        bus_valid = 1'b1;
        bus_write = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0;
        bus_write = 1'b0;
    endtask

    task automatic wait_idle(output logic [63:0] resp, output int cnt);
        logic [63:0] r, r1;
        cnt = 0;
        rd(12'hE20, 1'b1, r, r1);
        while (r[0] && cnt < 100) begin
            cnt++;
            @(negedge clk);
            rd(12'hE20, 1'b1, r, r1);
        end
        resp = r;
    endtask

    function automatic int lowest_free();
        for (int i = 1; i < NP; i++) if (!used[i]) return i;
        return 0;
    endfunction

    task automatic do_alloc(string req);
        logic [63:0] resp;
        int cnt;
        int exp_id;
        exp_id = lowest_free();
        wr(12'hE10, 64'h1, 1'b1);
        wait_idle(resp, cnt);
        if (exp_id != 0) begin
            chk(req, resp, 64'(exp_id) << 8);
            chk({req, " latency"}, 64'(cnt), 64'(1 + exp_id / WW));
            used[exp_id] = 1'b1;
        end else begin
            chk({req, " R7 full"}, resp, 64'h4);
            chk({req, " R7 latency"}, 64'(cnt), 64'(NP / WW));
        end
    endtask

    task automatic do_free(int id, string req);
        logic [63:0] resp;
        int cnt;
        bit ok;
        ok = (id > 0) && (id < NP) && used[id];
        wr(12'hE10, (64'(id) << 8) | 64'h2, 1'b1);
        wait_idle(resp, cnt);
        chk(req, resp, ok ? 64'h0 : 64'h4);
        chk({req, " latency"}, 64'(cnt), 64'd1);
        if (ok) used[id] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [63:0] d0, d1, resp;
        int cnt;
        for (int i = 0; i < NP; i++) used[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 / R1 reset state
        rd(12'hE00, 1'b1, d0, d1);
        chk("R1 cap u0", d0, 64'h1);
        chk("R1 cap u1", d1, 64'h0);
        rd(12'hE04, 1'b0, d0, d1);
        chk("R1 cap upper", d0, 64'h0);
        rd(12'hE10, 1'b1, d0, d1);
        chk("R11 cmd reset", d0, 64'h0);
        rd(12'hE20, 1'b1, d0, d1);
        chk("R11 resp reset", d0, 64'h0);

        // R1 cap writes ignored
        wr(12'hE00, '1, 1'b1);
        rd(12'hE00, 1'b1, d0, d1);
        chk("R1 cap write ignored", d0, 64'h1);

        // R4 busy word right after accept
        wr(12'hE10, 64'h1, 1'b1);
        rd(12'hE20, 1'b1, d0, d1);
        chk("R4 busy response", d0, 64'h1);
        wait_idle(resp, cnt);
        chk("R11 first alloc is 1", resp, 64'h100);
        used[1] = 1'b1;

        // R6 fill the pool
        for (int k = 2; k < NP; k++) do_alloc("R6 fill");
        do_alloc("R7 exhausted");

        // R9 invalid frees
        do_free(0, "R9 free zero");
        do_free(NP, "R9 free out of pool");
        do_free(20'hFFFFF, "R9 free max id");

        // R2 32-bit lower-half write issues free of 5
        wr(12'hE10, (64'd5 << 8) | 64'h2, 1'b0);
        wait_idle(resp, cnt);
        chk("R8 R2 free via low half", resp, 64'h0);
        used[5] = 1'b0;
        do_free(5, "R9 free not allocated");

        // R2 upper-half write keeps low opcode and merges
        wr(12'hE10, 64'h0000_0303, 1'b0);
        wait_idle(resp, cnt);
        chk("R10 undefined op 3", resp, 64'h2);
        wr(12'hE14, 64'hABCD_0000, 1'b0);
        wait_idle(resp, cnt);
        chk("R2 R10 upper write reissues op 3", resp, 64'h2);
        rd(12'hE10, 1'b1, d0, d1);
        chk("R2 cmd 64-bit readback", d0, 64'hABCD_0000_0000_0303);
        rd(12'hE14, 1'b0, d0, d1);
        chk("R2 cmd upper readback", d0, 64'hABCD_0000);
        rd(12'hE24, 1'b0, d0, d1);
        chk("R2 resp upper readback", d0, 64'h0);

        // R10 null and high opcodes
        wr(12'hE10, 64'h0, 1'b1);
        wait_idle(resp, cnt);
        chk("R10 null opcode", resp, 64'h2);
        chk("R10 latency", 64'(cnt), 64'd1);
        wr(12'hE10, 64'hFF, 1'b1);
        wait_idle(resp, cnt);
        chk("R10 opcode 0xFF", resp, 64'h2);

        // R8 free evens, refill lowest first
        for (int k = 2; k < NP; k += 2) do_free(k, "R8 free even");
        for (int k = 0; k < 33; k++) do_alloc("R6 R8 refill");
        do_alloc("R7 exhausted again");

        // R5 write during a long search
        do_free(60, "R8 free 60");
        wr(12'hE10, 64'h1, 1'b1);
        wr(12'hE10, (64'd1 << 8) | 64'h2, 1'b1);
        rd(12'hE10, 1'b1, d0, d1);
        chk("R5 cmd kept while busy", d0, 64'h1);
        wait_idle(resp, cnt);
        chk("R5 R6 search result", resp, 64'd60 << 8);
        used[60] = 1'b1;
        do_free(1, "R5 id 1 still allocated");

        // R3 block without allocation support
        rd(12'hE10, 1'b1, d0, d1);
        chk("R3 u1 cmd unchanged", d1, 64'h0);
        rd(12'hE20, 1'b1, d0, d1);
        chk("R3 u1 resp unchanged", d1, 64'h0);

        // R11 reset empties pool
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NP; i++) used[i] = 1'b0;
        rd(12'hE10, 1'b1, d0, d1);
        chk("R11 cmd after reset", d0, 64'h0);
        do_alloc("R11 alloc after reset");
        do_alloc("R11 second alloc");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule